// File: doc/BRIEF.md
# JTAG Scan Master with Register Control

This block lets software run instruction-register and data-register scans on an attached test access port. Software sets up a control word (master enable, external-port select, clock divider), loads an instruction word and a data word, and then writes a command word. The command carries a start bit, a 3-bit access type, and two width fields, each holding the bit count minus one. The block keeps its own copy of the TAP state. It drives TCK, TMS and TDI to move the TAP to the right shift state and shifts the requested bits least significant first. Each TDO bit it captures is written back into the data word at the position of that bit. A busy flag stays set from the start write until the scan is over.

Partial accesses shift their bits and then stay in the shift state. The next command continues the same shift from a freshly loaded word, so software can chain 32-bit pieces into scans of up to 64 bits. By default a scan ends by going through Update and stopping in Select-DR-Scan. The idle variants go through Update and stop in Run-Test/Idle instead.

Master states: `M_IDLE` (not busy), `M_DRIVE` (the next divider tick is a falling TCK edge, where TMS and TDI are updated), `M_RISE` (the next tick is a rising TCK edge, where the TAP copy advances and TDO is sampled), and `M_FINISH` (the final falling edge after the end state is reached). Transitions:
- IDLE→DRIVE on an accepted start.
- DRIVE→RISE on a tick.
- RISE→FINISH on a tick when the scan is complete.
- RISE→DRIVE on a tick otherwise.
- FINISH→IDLE on a tick.
- Any state→IDLE when enable is low.

Tracked TAP states: Test-Logic-Reset, Run-Test/Idle, Select-DR, Capture-DR, Shift-DR, Exit1-DR, Update-DR, Select-IR, Capture-IR, Shift-IR, Exit1-IR and Update-IR.

Top module: `jtag_scan_master`

## Requirements
- R1: After reset the outputs are TCK=0, TMS=1, TDI=0 and ext_tap=0, and the control and command words read as zero.
- R2: The block has four word addresses:
  - Address 0 is control: bit 0 enable, bit 1 external select, bits 15:8 divider.
  - Address 1 is the IR word.
  - Address 2 is the DR word.
  - Address 3 is the command word: bit 31 is start on write and busy on read, bits 18:16 the access type, bits 12:8 the IR width minus one, bits 4:0 the DR width minus one.
  - The access codes are 0 IR only, 1 DR only, 2 IR then DR, 3 partial IR, 4 partial DR, 5 IR then partial DR, 6 IR then DR ending idle, 7 DR ending idle.
  - Busy reads as 1 in the cycle after an accepted start.
- R3: A start write is ignored while busy or while enable is 0; the command fields read back unchanged.
- R4: While busy, TCK has a period of 2*(divider+1) system clocks. TCK is low whenever the block is not busy.
- R5: TMS and TDI change only together with a falling TCK edge, and never while TCK is high. TDO is sampled at the rising edge.
- R6: The first scan after reset, or after enable has been cleared, first gives five TCK cycles with TMS high and then one with TMS low to reach Run-Test/Idle.
- R7: IR and DR bits are shifted out least significant first. DR bit i is replaced by the i-th captured TDO bit. DR bits above the width keep their loaded value.
- R8: A non-partial shift raises TMS on its last bit and goes through Exit1 and Update. A default access then ends in Select-DR-Scan.
- R9: Access codes 6 and 7 end in Run-Test/Idle.
- R10: A partial access ends in its shift state. The next command continues that shift with no new Capture.
- R11: For an IR-then-DR access, the IR Update takes place before the DR Capture, and each happens once.
- R12: Clearing enable aborts a scan within one cycle: busy drops and TCK goes low. ext_tap equals external select AND enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Word address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data (combinational) |
| tck | output | 1 | Test clock |
| tms | output | 1 | Test mode select |
| tdi | output | 1 | Serial data to the TAP |
| tdo | input | 1 | Serial data from the TAP |
| ext_tap | output | 1 | Selects the external TAP |

## Verification
The assertions assume that TDO is stable when the rising TCK tick samples it. The bench's TAP model updates TDO only after a rising TCK edge, which meets this. The assertions also assume that software does not issue a command that contradicts the TAP's current shift state, such as a DR access that follows a partial IR. The directed scenarios only chain partial accesses with a command of the same register kind. Control writes are allowed at any time, so the check that TCK changes only on a divider tick exempts the cycle that follows an enable clear.

// File: rtl/jsm_pkg.sv
package jsm_pkg;
    typedef enum logic [3:0] {
        TS_TLR, TS_RTI, TS_SDR, TS_CDR, TS_SHDR, TS_E1DR, TS_UDR,
        TS_SIR, TS_CIR, TS_SHIR, TS_E1IR, TS_UIR
    } tap_st_e;

    typedef enum logic [2:0] {
        ACC_IR = 3'd0, ACC_DR = 3'd1, ACC_IRDR = 3'd2, ACC_PIR = 3'd3,
        ACC_PDR = 3'd4, ACC_IRPDR = 3'd5, ACC_IRDR_RTI = 3'd6, ACC_DR_RTI = 3'd7
    } acc_e;

    typedef enum logic [1:0] {M_IDLE, M_DRIVE, M_RISE, M_FINISH} mst_e;

    localparam logic [1:0] A_CTRL = 2'd0;
    localparam logic [1:0] A_IR   = 2'd1;
    localparam logic [1:0] A_DR   = 2'd2;
    localparam logic [1:0] A_CMD  = 2'd3;
endpackage

// File: rtl/jsm_tick_gen.sv
module jsm_tick_gen #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);
    logic [DIV_W-1:0] cnt_q;

    assign tick = run && (cnt_q == div);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)               cnt_q <= '0;
        else if (!run || tick)    cnt_q <= '0;
        else                      cnt_q <= cnt_q + 1'b1;
    end

    AST_NO_TICK_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> (cnt_q == '0)) else $error("tick counter not cleared"); // R4
endmodule

// File: rtl/jsm_tap_next.sv
module jsm_tap_next
    import jsm_pkg::*;
(
    input  tap_st_e cur,
    input  logic    tms,
    output tap_st_e nxt
);
    always_comb begin
        unique case (cur)
            TS_TLR:  nxt = tms ? TS_TLR  : TS_RTI;
            TS_RTI:  nxt = tms ? TS_SDR  : TS_RTI;
            TS_SDR:  nxt = tms ? TS_SIR  : TS_CDR;
            TS_CDR:  nxt = tms ? TS_E1DR : TS_SHDR;
            TS_SHDR: nxt = tms ? TS_E1DR : TS_SHDR;
            TS_E1DR: nxt = TS_UDR;
            TS_UDR:  nxt = tms ? TS_SDR  : TS_RTI;
            TS_SIR:  nxt = tms ? TS_TLR  : TS_CIR;
            TS_CIR:  nxt = tms ? TS_E1IR : TS_SHIR;
            TS_SHIR: nxt = tms ? TS_E1IR : TS_SHIR;
            TS_E1IR: nxt = TS_UIR;
            TS_UIR:  nxt = tms ? TS_SDR  : TS_RTI;
            default: nxt = TS_TLR;
        endcase
    end
endmodule

// File: rtl/jtag_scan_master.sv
module jtag_scan_master
    import jsm_pkg::*;
#(
    parameter int WORD_W    = 32,
    parameter int DIV_W     = 8,
    parameter int SYNC_CLKS = 5
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        reg_wr,
    input  logic [1:0]  reg_addr,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    output logic        tck,
    output logic        tms,
    output logic        tdi,
    input  logic        tdo,
    output logic        ext_tap
);
    localparam int CNT_W  = $clog2(WORD_W);
    localparam int SYNC_W = $clog2(SYNC_CLKS + 1);

    logic               en_q, ext_q;
    logic [DIV_W-1:0]   div_q;
    logic [WORD_W-1:0]  ir_q, dr_q;
    acc_e               acc_q;
    logic [CNT_W-1:0]   irw_q, drw_q, cnt_q;
    logic               pend_ir_q, pend_dr_q, ir_part_q, dr_part_q, idle_q;
    logic [SYNC_W-1:0]  sync_q;
    tap_st_e            ts_q, ts_nx;
    mst_e               m_st, m_nx;
    logic               tck_q, tms_q, tdi_q;
    logic               tick, busy, start_ok, tms_want, tdi_want;
    logic               shift_ir, shift_dr, last_ir, last_dr, pir_n, pdr_n, scan_done;
    acc_e               acc_w;

    assign busy  = (m_st != M_IDLE);
    assign acc_w = acc_e'(reg_wdata[18:16]);
    assign start_ok = reg_wr && (reg_addr == A_CMD) && reg_wdata[31] && en_q && !busy;

    jsm_tick_gen #(.DIV_W(DIV_W)) u_tick (
        .clk(clk), .rst_n(rst_n), .run(busy), .div(div_q), .tick(tick)
    );

    jsm_tap_next u_tap (.cur(ts_q), .tms(tms_q), .nxt(ts_nx));

    // bit bookkeeping for the rising edge
    assign shift_ir  = (ts_q == TS_SHIR) && pend_ir_q;
    assign shift_dr  = (ts_q == TS_SHDR) && pend_dr_q && !pend_ir_q;
    assign last_ir   = shift_ir && (cnt_q == irw_q);
    assign last_dr   = shift_dr && (cnt_q == drw_q);
    assign pir_n     = pend_ir_q && !last_ir;
    assign pdr_n     = pend_dr_q && !last_dr;
    assign scan_done = !pir_n && !pdr_n &&
                       (ts_nx == TS_SDR || ts_nx == TS_RTI || ts_nx == TS_SHIR || ts_nx == TS_SHDR);

    // TMS/TDI wanted for the next rising edge
    always_comb begin
        unique case (ts_q)
            TS_TLR:             tms_want = (sync_q != '0);
            TS_RTI:             tms_want = 1'b1;
            TS_SDR:             tms_want = pend_ir_q;
            TS_SIR, TS_CIR,
            TS_CDR:             tms_want = 1'b0;
            TS_SHIR:            tms_want = pend_ir_q ? ((cnt_q == irw_q) && !ir_part_q) : 1'b1;
            TS_SHDR:            tms_want = (pend_dr_q && !pend_ir_q) ?
                                           ((cnt_q == drw_q) && !dr_part_q) : 1'b1;
            TS_E1IR, TS_E1DR:   tms_want = 1'b1;
            TS_UIR, TS_UDR:     tms_want = (pend_ir_q || pend_dr_q) ? 1'b1 : !idle_q;
            default:            tms_want = 1'b1;
        endcase
        tdi_want = (ts_q == TS_SHIR) ? ir_q[cnt_q] :
                   (ts_q == TS_SHDR) ? dr_q[cnt_q] : 1'b0;
    end

    // master next state
    always_comb begin
        m_nx = m_st;
        unique case (m_st)
            M_IDLE:   if (start_ok) m_nx = M_DRIVE;
            M_DRIVE:  if (tick)     m_nx = M_RISE;
            M_RISE:   if (tick)     m_nx = scan_done ? M_FINISH : M_DRIVE;
            M_FINISH: if (tick)     m_nx = M_IDLE;
            default:                m_nx = M_IDLE;
        endcase
        if (!en_q) m_nx = M_IDLE;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) m_st <= M_IDLE;
        else        m_st <= m_nx;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q <= 1'b0;  ext_q <= 1'b0;  div_q <= '0;
            ir_q <= '0;    dr_q <= '0;     acc_q <= ACC_IR;
            irw_q <= '0;   drw_q <= '0;    cnt_q <= '0;
            pend_ir_q <= 1'b0; pend_dr_q <= 1'b0;
            ir_part_q <= 1'b0; dr_part_q <= 1'b0; idle_q <= 1'b0;
            sync_q <= SYNC_W'(SYNC_CLKS); ts_q <= TS_TLR;
            tck_q <= 1'b0; tms_q <= 1'b1; tdi_q <= 1'b0;
        end else begin
            if (reg_wr && reg_addr == A_CTRL) begin
                en_q  <= reg_wdata[0];
                ext_q <= reg_wdata[1];
                div_q <= reg_wdata[8 +: DIV_W];
            end
            if (reg_wr && reg_addr == A_IR && !busy) ir_q <= reg_wdata[WORD_W-1:0];
            if (reg_wr && reg_addr == A_DR && !busy) dr_q <= reg_wdata[WORD_W-1:0];
            if (!en_q) begin
                ts_q <= TS_TLR; sync_q <= SYNC_W'(SYNC_CLKS); tck_q <= 1'b0;
                pend_ir_q <= 1'b0; pend_dr_q <= 1'b0;
            end else begin
                unique case (m_st)
                    M_IDLE: if (start_ok) begin
                        acc_q     <= acc_w;
                        irw_q     <= reg_wdata[8 +: CNT_W];
                        drw_q     <= reg_wdata[0 +: CNT_W];
                        cnt_q     <= '0;
                        pend_ir_q <= acc_w inside {ACC_IR, ACC_IRDR, ACC_PIR, ACC_IRPDR, ACC_IRDR_RTI};
                        pend_dr_q <= !(acc_w inside {ACC_IR, ACC_PIR});
                        ir_part_q <= (acc_w == ACC_PIR);
                        dr_part_q <= acc_w inside {ACC_PDR, ACC_IRPDR};
                        idle_q    <= acc_w inside {ACC_IRDR_RTI, ACC_DR_RTI};
                    end
                    M_DRIVE: if (tick) begin
                        tck_q <= 1'b0; tms_q <= tms_want; tdi_q <= tdi_want;
                    end
                    M_RISE: if (tick) begin
                        tck_q <= 1'b1;
                        ts_q  <= ts_nx;
                        if (ts_q == TS_TLR && sync_q != '0) sync_q <= sync_q - 1'b1;
                        if (shift_ir) cnt_q <= last_ir ? '0 : cnt_q + 1'b1;
                        if (shift_dr) begin
                            dr_q[cnt_q] <= tdo;
                            cnt_q <= last_dr ? '0 : cnt_q + 1'b1;
                        end
                        pend_ir_q <= pir_n;
                        pend_dr_q <= pdr_n;
                    end
                    M_FINISH: if (tick) tck_q <= 1'b0;
                    default: ;
                endcase
            end
        end
    end

    always_comb begin
        reg_rdata = '0;
        unique case (reg_addr)
            A_CTRL: begin
                reg_rdata[0] = en_q;
                reg_rdata[1] = ext_q;
                reg_rdata[8 +: DIV_W] = div_q;
            end
            A_IR:   reg_rdata[WORD_W-1:0] = ir_q;
            A_DR:   reg_rdata[WORD_W-1:0] = dr_q;
            default: begin
                reg_rdata[31]    = busy;
                reg_rdata[18:16] = acc_q;
                reg_rdata[8 +: CNT_W] = irw_q;
                reg_rdata[0 +: CNT_W] = drw_q;
            end
        endcase
    end

    assign tck     = tck_q;
    assign tms     = tms_q;
    assign tdi     = tdi_q;
    assign ext_tap = en_q & ext_q;

    AST_IDLE_TCK_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !tck_q) else $error("tck high while idle"); // R4
    AST_TCK_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        (tck_q != $past(tck_q)) |-> ($past(tick) || !$past(en_q))) else $error("tck edge off tick"); // R4
    AST_PINS_HOLD_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (tck_q && $past(tck_q)) |-> ($stable(tms_q) && $stable(tdi_q))) else $error("pin moved with tck high"); // R5
    AST_EXIT_TO_UPDATE: assert property (@(posedge clk) disable iff (!rst_n)
        (m_st == M_RISE && tick && (ts_q == TS_E1IR || ts_q == TS_E1DR)) |-> tms_q) else $error("exit without tms"); // R8
    AST_BUSY_START_IGN: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && reg_wr && reg_addr == A_CMD) |=> ($stable(acc_q) && $stable(irw_q) && $stable(drw_q)))
        else $error("command taken while busy"); // R3
    AST_END_STATE: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(busy) && !busy && $past(en_q)) |->
        (ts_q == TS_SDR || ts_q == TS_RTI || ts_q == TS_SHIR || ts_q == TS_SHDR)) else $error("bad end state"); // R8
endmodule

// File: tb/tb_jtag_scan_master.sv
module tb_jtag_scan_master;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [1:0]  reg_addr = 2'd0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        tck, tms, tdi, tdo, ext_tap;

    int n_tests = 0, n_fail = 0;
    int cyc = 0, last_rise = 0, tck_per = 0, n_rise = 0;
    int tap_s = 0, tlr_hi = 0, ir_n = 0, dr_n = 0;
    int cap_dr = 0, cap_ir = 0, upd_dr = 0, upd_ir = 0, upd_ir_at_cap = 0, viol = 0;
    logic ir_log [0:511];
    logic dr_log [0:511];
    logic prev_tck = 0, prev_tms = 0, prev_tdi = 0;
    localparam logic [63:0] PAT = 64'hC3A5_0F96_7E18_D24B;

    always #5 clk = ~clk;

    jtag_scan_master dut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .tck(tck), .tms(tms),
        .tdi(tdi), .tdo(tdo), .ext_tap(ext_tap)
    );

    // independent full TAP model: 0 TLR 1 RTI 2 SDR 3 CDR 4 SHDR 5 E1DR 6 PDR 7 E2DR 8 UDR
    // 9 SIR 10 CIR 11 SHIR 12 E1IR 13 PIR 14 E2IR 15 UIR
    function automatic int tap_nx(int s, logic m);
        case (s)
            0: return m ? 0 : 1;     1: return m ? 2 : 1;
            2: return m ? 9 : 3;     3: return m ? 5 : 4;
            4: return m ? 5 : 4;     5: return m ? 8 : 6;
            6: return m ? 7 : 6;     7: return m ? 8 : 4;
            8: return m ? 2 : 1;     9: return m ? 0 : 10;
            10: return m ? 12 : 11;  11: return m ? 12 : 11;
            12: return m ? 15 : 13;  13: return m ? 14 : 13;
            14: return m ? 15 : 11;  default: return m ? 2 : 1;
        endcase
    endfunction

    assign tdo = PAT[dr_n & 63];

    always @(posedge clk) cyc <= cyc + 1;

    always @(posedge tck) begin
        if (tap_s == 0 && tms) tlr_hi = tlr_hi + 1;
        if (tap_s == 11) begin ir_log[ir_n] = tdi; ir_n = ir_n + 1; end
        if (tap_s == 4)  begin dr_log[dr_n] = tdi; dr_n = dr_n + 1; end
        if (tap_s == 3)  begin cap_dr = cap_dr + 1; upd_ir_at_cap = upd_ir; end
        if (tap_s == 10) cap_ir = cap_ir + 1;
        if (tap_s == 8)  upd_dr = upd_dr + 1;
        if (tap_s == 15) upd_ir = upd_ir + 1;
        tap_s = tap_nx(tap_s, tms);
        tck_per = cyc - last_rise;
        last_rise = cyc;
        n_rise = n_rise + 1;
    end

    always @(negedge clk) begin
        if (rst_n && tck && prev_tck && (tms != prev_tms || tdi != prev_tdi)) viol = viol + 1;
        prev_tck = tck; prev_tms = tms; prev_tdi = tdi;
    end

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic reg_write(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk); reg_wr = 1'b0;
    endtask

    task automatic reg_read(input logic [1:0] a, output logic [31:0] d);
        @(negedge clk); reg_addr = a; #1 d = reg_rdata;
    endtask

    function automatic logic [31:0] cmd_word(input int acc, input int irw, input int drw);
        logic [31:0] c = '0;
        c[31] = 1'b1; c[18:16] = acc[2:0]; c[12:8] = irw[4:0]; c[4:0] = drw[4:0];
        return c;
    endfunction

    task automatic wait_idle();
        logic [31:0] d;
        for (int i = 0; i < 20000; i++) begin
            reg_read(2'd3, d);
            if (!d[31]) return;
        end
    endtask

    function automatic logic [63:0] ir_bits(input int base, input int n);
        logic [63:0] r = '0;
        for (int i = 0; i < n; i++) r[i] = ir_log[base + i];
        return r;
    endfunction

    function automatic logic [63:0] dr_bits(input int base, input int n);
        logic [63:0] r = '0;
        for (int i = 0; i < n; i++) r[i] = dr_log[base + i];
        return r;
    endfunction

    function automatic logic [31:0] pat_bits(input int base, input int n);
        logic [31:0] r = '0;
        for (int i = 0; i < n; i++) r[i] = PAT[(base + i) & 63];
        return r;
    endfunction

    task automatic t_reset();
        logic [31:0] d;
        chk(tck == 1'b0 && tms == 1'b1 && tdi == 1'b0, "R1 pins", {tck, tms, tdi}, 3'b010);
        chk(ext_tap == 1'b0, "R1 ext_tap", ext_tap, 0);
        reg_read(2'd0, d); chk(d == 0, "R1 ctrl", d, 0);
        reg_read(2'd3, d); chk(d == 0, "R1 cmd", d, 0);
    endtask

    task automatic t_disabled_start();
        logic [31:0] d;
        int r0 = n_rise;
        reg_write(2'd3, cmd_word(0, 3, 0));
        reg_read(2'd3, d);
        chk(d[31] == 1'b0, "R3 start while disabled", d[31], 0);
        repeat (20) @(negedge clk);
        chk(n_rise == r0, "R3 no tck while disabled", n_rise, r0);
    endtask

    task automatic t_enable();
        logic [31:0] d;
        reg_write(2'd0, 32'h0000_0303);
        reg_read(2'd0, d);
        chk(d == 32'h0000_0303, "R2 ctrl readback", d, 32'h303);
        chk(ext_tap == 1'b1, "R12 ext_tap on", ext_tap, 1);
    endtask

    task automatic t_ir_only();
        logic [31:0] d;
        int b = ir_n, u = upd_ir;
        reg_write(2'd1, 32'h0000_002D);
        reg_write(2'd3, cmd_word(0, 5, 0));
        reg_read(2'd3, d);
        chk(d[31] == 1'b1, "R2 busy after start", d[31], 1);
        wait_idle();
        chk(tlr_hi == 5, "R6 five TMS-high clocks", tlr_hi, 5);
        chk(tck_per == 8, "R4 tck period", tck_per, 8);
        chk(ir_bits(b, 6) == 64'h2D && ir_n - b == 6, "R7 IR bits", ir_bits(b, 6), 64'h2D);
        chk(tap_s == 2 && upd_ir == u + 1, "R8 IR end in Select-DR", tap_s, 2);
        chk(tck == 1'b0, "R4 tck low idle", tck, 0);
    endtask

    task automatic t_dr_only();
        logic [31:0] d;
        int b = dr_n, u = upd_dr;
        reg_write(2'd2, 32'hA5A5_F0F0);
        reg_write(2'd3, cmd_word(1, 0, 11));
        repeat (10) @(negedge clk);
        reg_write(2'd3, cmd_word(0, 31, 0));
        wait_idle();
        reg_read(2'd3, d);
        chk(d[18:16] == 3'd1 && d[12:8] == 5'd0 && d[4:0] == 5'd11, "R3 start while busy", d, 32'h0001_000B);
        chk(dr_bits(b, 12) == 64'h0F0 && dr_n - b == 12, "R7 DR bits out", dr_bits(b, 12), 64'h0F0);
        reg_read(2'd2, d);
        chk(d == {20'hA5A5F, pat_bits(b, 12)[11:0]}, "R7 DR capture", d, {20'hA5A5F, pat_bits(b, 12)[11:0]});
        chk(tap_s == 2 && upd_dr == u + 1, "R8 DR end in Select-DR", tap_s, 2);
    endtask

    task automatic t_irdr_idle();
        int ci = cap_dr, ui = upd_ir, bi = ir_n, bd = dr_n;
        reg_write(2'd1, 32'h0000_0006);
        reg_write(2'd2, 32'h0000_00C9);
        reg_write(2'd3, cmd_word(6, 3, 7));
        wait_idle();
        chk(tap_s == 1, "R9 idle end", tap_s, 1);
        chk(cap_dr == ci + 1 && upd_ir == ui + 1 && upd_ir_at_cap == ui + 1,
            "R11 IR update before DR capture", upd_ir_at_cap, ui + 1);
        chk(ir_bits(bi, 4) == 64'h6 && dr_bits(bd, 8) == 64'hC9, "R11 IR and DR bits",
            {ir_bits(bi, 4)[31:0], dr_bits(bd, 8)[31:0]}, {32'h6, 32'hC9});
    endtask

    task automatic t_partial_dr();
        logic [31:0] d;
        int c0 = cap_dr, b = dr_n;
        reg_write(2'd2, 32'h1357_9BDF);
        reg_write(2'd3, cmd_word(4, 0, 31));
        wait_idle();
        chk(tap_s == 4, "R10 partial DR stays in shift", tap_s, 4);
        reg_read(2'd2, d);
        chk(d == pat_bits(b, 32), "R10 first DR piece capture", d, pat_bits(b, 32));
        reg_write(2'd2, 32'hFFFF_FF5A);
        reg_write(2'd3, cmd_word(1, 0, 7));
        wait_idle();
        chk(cap_dr == c0 + 1, "R10 one DR capture", cap_dr, c0 + 1);
        chk(dr_bits(b, 32) == 64'h1357_9BDF && dr_bits(b + 32, 8) == 64'h5A,
            "R10 chained DR bits", dr_bits(b + 32, 8), 64'h5A);
        reg_read(2'd2, d);
        chk(d == {24'hFFFFFF, pat_bits(b + 32, 8)[7:0]}, "R10 second piece capture", d,
            {24'hFFFFFF, pat_bits(b + 32, 8)[7:0]});
        chk(tap_s == 2, "R8 chained end state", tap_s, 2);
    endtask

    task automatic t_partial_ir();
        int c0 = cap_ir, b = ir_n;
        reg_write(2'd1, 32'h1234_5678);
        reg_write(2'd3, cmd_word(3, 31, 0));
        wait_idle();
        chk(tap_s == 11, "R10 partial IR stays in shift", tap_s, 11);
        reg_write(2'd1, 32'h0000_000B);
        reg_write(2'd3, cmd_word(2, 3, 4));
        wait_idle();
        chk(cap_ir == c0 + 1, "R10 one IR capture", cap_ir, c0 + 1);
        chk(ir_bits(b, 36) == 64'hB_1234_5678, "R10 chained IR bits", ir_bits(b, 36), 64'hB_1234_5678);
        chk(tap_s == 2, "R8 IR chain end", tap_s, 2);
    endtask

    task automatic t_abort();
        logic [31:0] d;
        int b;
        reg_write(2'd0, 32'h0000_3203);
        reg_write(2'd3, cmd_word(1, 0, 31));
        repeat (400) @(negedge clk);
        reg_write(2'd0, 32'h0000_3202);
        @(negedge clk);
        reg_read(2'd3, d);
        chk(d[31] == 1'b0 && tck == 1'b0, "R12 abort", {d[31], tck}, 0);
        chk(ext_tap == 1'b0, "R12 ext_tap off", ext_tap, 0);
        reg_write(2'd0, 32'h0000_0301);
        b = ir_n;
        reg_write(2'd1, 32'h0000_00A5);
        reg_write(2'd3, cmd_word(0, 7, 0));
        wait_idle();
        chk(tap_s == 2 && ir_bits(b, 8) == 64'hA5, "R6 resync after abort", ir_bits(b, 8), 64'hA5);
    endtask

    initial begin
        #2_000_000;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_disabled_start();
        t_enable();
        t_ir_only();
        t_dr_only();
        t_irdr_idle();
        t_partial_dr();
        t_partial_ir();
        t_abort();
        chk(viol == 0, "R5 TMS/TDI stable while TCK high", viol, 0);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule